// File: doc/BRIEF.md
# Pixel Repeater and Multi-Segment Splitter

This output-buffer stage takes one line of active pixels as a valid/ready stream with an end-of-line marker. It emits every accepted pixel a programmable number of extra times on consecutive cycles. While a pixel is being repeated, the input is held off.

The stage also divides the line horizontally into one, two or four segments for a panel that is driven as several independent strips. Each segment has its own output lane with a valid bit and a copy of the pixel. Pixels that lie within a programmable overlap distance of a segment boundary appear on both neighbouring lanes in the same cycle. The lane number serves as the segment index.

Segment width is derived from a programmed active width. If that width does not split evenly into the chosen number of segments, an error flag is raised and the whole line goes to lane 0.

Top module: `pix_repeat_splitter`

## Requirements
- R1: While and just after reset, every lane valid is 0, the error flag is 0 and in_ready is 1.
- R2: Each accepted pixel appears on the outputs for exactly cfg_rep+1 consecutive cycles, with no gap between them. cfg_rep ranges from 0 to 15, and 0 means no repetition.
- R3: After a pixel is accepted, in_ready stays low for exactly cfg_rep cycles. A source that holds in_valid during that time is stalled, and none of its pixels is lost.
- R4: cfg_mode selects the segment count S and the line length L. Mode 0 gives S=1 and L=W. Mode 1 gives S=2 and L=W. Mode 2 gives S=4 and L=W. Mode 3 gives S=4 and L=2W, because in that left/right split mode cfg_width holds half the panel width.
- R5: The segment length is L/S. Lane s is valid for column c exactly when s<S, c+V ≥ s·L/S and c < (s+1)·L/S+V, where V is the effective overlap.
- R6: The effective overlap V is cfg_overlap clamped to the range 1..8. A value of 0 acts as 1, and values above 8 act as 8.
- R7: If L is not a multiple of S, cfg_err is 1 and all pixels appear on lane 0 only. Otherwise cfg_err is 0.
- R8: Columns count from 0 and restart after the pixel marked with in_eol. out_col gives the column of the pixel on the outputs, and columns appear in increasing order.
- R9: A valid lane carries the accepted pixel on its data field. A lane that is not valid carries zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rep | input | REP_W | Extra repetitions per pixel |
| cfg_mode | input | 2 | Segment mode (see R4) |
| cfg_overlap | input | OVL_W | Overlap pixels at each boundary |
| cfg_width | input | WIDTH_W | Active width W |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_pixel | input | PIX_W | Input pixel data |
| in_eol | input | 1 | Last pixel of the line |
| out_valid | output | 4 | Per-lane valid; bit s is segment s |
| out_data | output | 4*PIX_W | Per-lane pixel, lane s at bits s*PIX_W upward |
| out_col | output | WIDTH_W+1 | Column of the pixel being emitted |
| cfg_err | output | 1 | Width not divisible by segment count |

## Verification
Two functions can act in the same cycle. A boundary pixel can go onto two lanes at once, and that same pixel is also held for its repeat cycles. The sweep runs every mode with overlaps at, below and above the clamp limits, in lines that have and lines that lack idle input gaps. Each output cycle is checked lane by lane against a mask worked out arithmetically from the column. The length of each run of repeats is also checked, so a boundary pixel must keep its two-lane pattern for all cfg_rep+1 cycles.

// File: rtl/pix_repeat_pkg.sv
package pix_repeat_pkg;

  typedef enum logic [1:0] {
    SEG_ONE        = 2'd0,
    SEG_TWO        = 2'd1,
    SEG_FOUR       = 2'd2,
    SEG_FOUR_SPLIT = 2'd3
  } seg_mode_e;

  // log2 of the segment count requested by a mode
  function automatic logic [1:0] seg_log2(input seg_mode_e m);
    case (m)
      SEG_ONE: seg_log2 = 2'd0;
      SEG_TWO: seg_log2 = 2'd1;
      default: seg_log2 = 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/pix_seg_geom.sv
// Decodes the segment configuration into segment length, effective overlap
// and a divisibility error (R4, R6, R7).
module pix_seg_geom
  import pix_repeat_pkg::*;
#(
  parameter int WIDTH_W = 13,
  parameter int LINE_W  = WIDTH_W + 1,
  parameter int OVL_W   = 4,
  parameter int MAX_OVL = 8
) (
  input  logic [1:0]         mode,
  input  logic [WIDTH_W-1:0] width,
  input  logic [OVL_W-1:0]   ovl_req,
  output logic [1:0]         seg_lg,
  output logic [LINE_W-1:0]  seg_len,
  output logic [OVL_W-1:0]   ovl_eff,
  output logic               err
);

  seg_mode_e         mode_e;
  logic [1:0]        lg_req;
  logic [LINE_W-1:0] line_len;
  logic [LINE_W-1:0] low_mask;

  always_comb begin
    mode_e   = seg_mode_e'(mode);
    lg_req   = seg_log2(mode_e);
    // split mode: width field holds half the panel line
    line_len = (mode_e == SEG_FOUR_SPLIT) ? {width, 1'b0} : {1'b0, width};
    low_mask = (LINE_W'(1) << lg_req) - LINE_W'(1);
    err      = |(line_len & low_mask);
    seg_lg   = err ? 2'd0 : lg_req;
    seg_len  = line_len >> seg_lg;
    if (ovl_req == '0)
      ovl_eff = OVL_W'(1);
    else if (ovl_req > OVL_W'(MAX_OVL))
      ovl_eff = OVL_W'(MAX_OVL);
    else
      ovl_eff = ovl_req;
  end

endmodule

// File: rtl/pix_lane_mask.sv
// Per-lane membership of a column, including the overlap band (R5).
module pix_lane_mask #(
  parameter int LINE_W = 14,
  parameter int OVL_W  = 4,
  parameter int LANES  = 4
) (
  input  logic [LINE_W-1:0] col,
  input  logic [LINE_W-1:0] seg_len,
  input  logic [1:0]        seg_lg,
  input  logic [OVL_W-1:0]  ovl,
  output logic [LANES-1:0]  mask
);

  localparam int CMP_W = LINE_W + 3;

  logic [3:0] seg_cnt;
  assign seg_cnt = 4'd1 << seg_lg;

  for (genvar s = 0; s < LANES; s++) begin : g_lane
    logic [CMP_W-1:0] lo, hi, lead, col_x;
    always_comb begin
      lo    = CMP_W'(s) * CMP_W'(seg_len);
      hi    = lo + CMP_W'(seg_len) + CMP_W'(ovl);
      col_x = CMP_W'(col);
      lead  = col_x + CMP_W'(ovl);
    end
    assign mask[s] = (4'(s) < seg_cnt) && (lead >= lo) && (col_x < hi);
  end

endmodule

// File: rtl/pix_rep_core.sv
// Capture, repetition count, column tracking and registered lane outputs.
module pix_rep_core #(
  parameter int PIX_W  = 24,
  parameter int REP_W  = 4,
  parameter int LINE_W = 14,
  parameter int LANES  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [REP_W-1:0]       rep,
  input  logic [LANES-1:0]       lane_sel,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [PIX_W-1:0]       in_pixel,
  input  logic                   in_eol,
  output logic [LINE_W-1:0]      col,
  output logic [LANES-1:0]       out_valid,
  output logic [LANES*PIX_W-1:0] out_data,
  output logic [LINE_W-1:0]      out_col
);

  logic [REP_W-1:0] left_q;
  logic             take;

  assign in_ready = (left_q == '0);
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q    <= '0;
      col       <= '0;
      out_valid <= '0;
      out_col   <= '0;
    end else if (take) begin
      left_q    <= rep;
      out_valid <= lane_sel;
      out_col   <= col;
      col       <= in_eol ? '0 : col + LINE_W'(1);
    end else if (left_q != '0) begin
      left_q <= left_q - REP_W'(1);
    end else begin
      out_valid <= '0;
    end
  end

  for (genvar s = 0; s < LANES; s++) begin : g_data
    logic [PIX_W-1:0] data_q;
    always_ff @(posedge clk) begin
      if (rst)
        data_q <= '0;
      else if (take)
        data_q <= lane_sel[s] ? in_pixel : '0;
      else if (left_q == '0)
        data_q <= '0;
    end
    assign out_data[s*PIX_W +: PIX_W] = data_q;
  end

endmodule

// File: rtl/pix_repeat_splitter.sv
module pix_repeat_splitter
  import pix_repeat_pkg::*;
#(
  parameter int PIX_W   = 24,
  parameter int WIDTH_W = 13,
  parameter int REP_W   = 4,
  parameter int OVL_W   = 4,
  parameter int MAX_OVL = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [REP_W-1:0]       cfg_rep,
  input  logic [1:0]             cfg_mode,
  input  logic [OVL_W-1:0]       cfg_overlap,
  input  logic [WIDTH_W-1:0]     cfg_width,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [PIX_W-1:0]       in_pixel,
  input  logic                   in_eol,
  output logic [3:0]             out_valid,
  output logic [4*PIX_W-1:0]     out_data,
  output logic [WIDTH_W:0]       out_col,
  output logic                   cfg_err
);

  localparam int LANES  = 4;
  localparam int LINE_W = WIDTH_W + 1;

  logic [1:0]        seg_lg;
  logic [LINE_W-1:0] seg_len;
  logic [OVL_W-1:0]  ovl_eff;
  logic              geom_err;
  logic [LINE_W-1:0] cur_col;
  logic [LANES-1:0]  lane_sel;

  pix_seg_geom #(
    .WIDTH_W(WIDTH_W), .LINE_W(LINE_W), .OVL_W(OVL_W), .MAX_OVL(MAX_OVL)
  ) u_geom (
    .mode(cfg_mode), .width(cfg_width), .ovl_req(cfg_overlap),
    .seg_lg(seg_lg), .seg_len(seg_len), .ovl_eff(ovl_eff), .err(geom_err)
  );

  pix_lane_mask #(
    .LINE_W(LINE_W), .OVL_W(OVL_W), .LANES(LANES)
  ) u_mask (
    .col(cur_col), .seg_len(seg_len), .seg_lg(seg_lg), .ovl(ovl_eff),
    .mask(lane_sel)
  );

  pix_rep_core #(
    .PIX_W(PIX_W), .REP_W(REP_W), .LINE_W(LINE_W), .LANES(LANES)
  ) u_core (
    .clk(clk), .rst(rst), .rep(cfg_rep), .lane_sel(lane_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_pixel(in_pixel),
    .in_eol(in_eol), .col(cur_col), .out_valid(out_valid),
    .out_data(out_data), .out_col(out_col)
  );

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= geom_err;
  end

endmodule

// File: rtl/pix_repeat_splitter_chk.sv
module pix_repeat_splitter_chk #(
  parameter int PIX_W = 24,
  parameter int REP_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [REP_W-1:0]   cfg_rep,
  input logic [1:0]         cfg_mode,
  input logic               in_ready,
  input logic [3:0]         out_valid,
  input logic [4*PIX_W-1:0] out_data,
  input logic               cfg_err
);

  // R1: outputs idle right after a reset cycle
  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (out_valid == 4'd0 && !cfg_err));

  // R3: input held off only while a pixel is on the outputs
  a_r3_stall_only_repeating: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (out_valid != 4'd0));

  // R2: lane outputs frozen across a repeat
  a_r2_hold_during_repeat: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> ($stable(out_data) && $stable(out_valid)));

  // R2: no repetition means never stalled
  a_r2_rep0_ready: assert property (@(posedge clk) disable iff (rst)
    (cfg_rep == '0) |-> in_ready);

  // R4: single-segment mode uses lane 0 only
  a_r4_single_lane: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'd0) |-> (out_valid[3:1] == 3'd0));

  // R7: error forces lane 0 only
  a_r7_err_lane0: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (out_valid[3:1] == 3'd0));

endmodule

bind pix_repeat_splitter pix_repeat_splitter_chk #(
  .PIX_W(PIX_W), .REP_W(REP_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_rep(cfg_rep), .cfg_mode(cfg_mode),
  .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
  .cfg_err(cfg_err)
);

// File: tb/tb_pix_repeat_splitter.sv
module tb_pix_repeat_splitter;

  localparam int PIX_W   = 12;
  localparam int WIDTH_W = 6;
  localparam int REP_W   = 4;
  localparam int OVL_W   = 4;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [REP_W-1:0]     cfg_rep = '0;
  logic [1:0]           cfg_mode = '0;
  logic [OVL_W-1:0]     cfg_overlap = '0;
  logic [WIDTH_W-1:0]   cfg_width = '0;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic [PIX_W-1:0]     in_pixel = '0;
  logic                 in_eol = 1'b0;
  logic [3:0]           out_valid;
  logic [4*PIX_W-1:0]   out_data;
  logic [WIDTH_W:0]     out_col;
  logic                 cfg_err;

  always #10 clk = ~clk;  // 50 MHz

  pix_repeat_splitter #(
    .PIX_W(PIX_W), .WIDTH_W(WIDTH_W), .REP_W(REP_W), .OVL_W(OVL_W), .MAX_OVL(8)
  ) dut (
    .clk(clk), .rst(rst), .cfg_rep(cfg_rep), .cfg_mode(cfg_mode),
    .cfg_overlap(cfg_overlap), .cfg_width(cfg_width), .in_valid(in_valid),
    .in_ready(in_ready), .in_pixel(in_pixel), .in_eol(in_eol),
    .out_valid(out_valid), .out_data(out_data), .out_col(out_col),
    .cfg_err(cfg_err)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // expected-model configuration
  int e_mode, e_w, e_rep, e_ov, line_id;
  bit mon_en = 0;
  int next_col, pix_seen, run_len;
  logic [PIX_W-1:0] run_pix;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int seg_count(input int mode);
    return (mode == 0) ? 1 : (mode == 1) ? 2 : 4;
  endfunction

  function automatic int line_len(input int mode, input int w);
    return (mode == 3) ? 2 * w : w;
  endfunction

  function automatic bit exp_err(input int mode, input int w);
    return (line_len(mode, w) % seg_count(mode)) != 0;
  endfunction

  function automatic int exp_mask(input int col);
    int s_cnt, len, seg, ov, m;
    len   = line_len(e_mode, e_w);
    s_cnt = exp_err(e_mode, e_w) ? 1 : seg_count(e_mode);
    seg   = len / s_cnt;
    ov    = (e_ov == 0) ? 1 : (e_ov > 8 ? 8 : e_ov);
    m = 0;
    for (int s = 0; s < 4; s++)
      if (s < s_cnt && col + ov >= s * seg && col < (s + 1) * seg + ov)
        m |= (1 << s);
    return m;
  endfunction

  task automatic close_run();
    if (run_len > 0) chk("R2 repeat run length", run_len, e_rep + 1);
    run_len = 0;
  endtask

  // output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (mon_en) begin
      if (out_valid != 4'd0) begin
        logic [PIX_W-1:0] pix;
        int col;
        pix = '0;
        for (int s = 3; s >= 0; s--)
          if (out_valid[s]) pix = out_data[s*PIX_W +: PIX_W];
        for (int s = 0; s < 4; s++)
          chk("R9 lane data", int'(out_data[s*PIX_W +: PIX_W]),
              out_valid[s] ? int'(pix) : 0);
        col = int'(pix[5:0]);
        chk("R8 out_col", int'(out_col), col);
        chk("R5 lane mask", int'(out_valid), exp_mask(col));
        if (run_len > 0 && pix == run_pix) begin
          run_len++;
        end else begin
          close_run();
          chk("R8 column order", col, next_col);
          chk("R8 line tag", int'(pix[11:6]), line_id & 63);
          next_col = col + 1;
          run_pix  = pix;
          run_len  = 1;
          pix_seen++;
        end
      end else begin
        close_run();
      end
    end
  end

  task automatic run_line(input int mode, input int w, input int rep,
                          input int ov, input bit gaps);
    int len, lows;
    cfg_mode    = 2'(mode);
    cfg_width   = WIDTH_W'(w);
    cfg_rep     = REP_W'(rep);
    cfg_overlap = OVL_W'(ov);
    e_mode = mode; e_w = w; e_rep = rep; e_ov = ov;
    repeat (3) @(negedge clk);
    chk("R7 cfg_err", int'(cfg_err), int'(exp_err(mode, w)));
    len = line_len(mode, w);
    line_id++;
    next_col = 0; pix_seen = 0; run_len = 0;
    mon_en = 1;
    for (int c = 0; c < len; c++) begin
      in_valid = 1'b1;
      in_pixel = {6'(line_id), 6'(c)};
      in_eol   = (c == len - 1);
      @(posedge clk);
      @(negedge clk);
      lows = 0;
      while (!in_ready) begin
        lows++;
        @(negedge clk);
      end
      chk("R3 ready low cycles", lows, rep);
      if (gaps && (c % 5) == 3) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    in_eol   = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 pixels per line", pix_seen, len);
    mon_en = 0;
  endtask

  initial begin
    int widths[3];
    int reps[3];
    int ovs[5];
    widths = '{16, 18, 17};
    reps   = '{0, 2, 15};
    ovs    = '{0, 1, 3, 8, 12};
    line_id = 0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", int'(out_valid), 0);
    chk("R1 ready in reset", int'(in_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", int'(out_valid), 0);
    chk("R1 err after reset", int'(cfg_err), 0);
    for (int m = 0; m < 4; m++)          // R4 all modes
      for (int wi = 0; wi < 3; wi++)
        for (int ri = 0; ri < 3; ri++)
          for (int oi = 0; oi < 5; oi++) // R6 clamp ends included
            run_line(m, widths[wi], reps[ri], ovs[oi], ((oi + ri) % 2) == 1);
    // narrow segments: overlap spans more than one neighbour (R5)
    run_line(2, 8, 1, 8, 1'b0);
    run_line(3, 4, 3, 5, 1'b1);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule